// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs the external memory bus of an 8-bit controller core. The bus multiplexes the low address byte with data on one 8-bit port and puts the high address byte on a second port. The core hands over one request per machine cycle: an idle cycle, a code fetch, a data read, or a data write. The sequencer then plays a fixed schedule of address-latch pulses, strobes and port drive over the 12 input clocks of that machine cycle. Read data from a code fetch or a data read comes back with a one-clock valid pulse.

A machine cycle has six states of two input clocks each. The clocks are numbered 0 to 11 within the cycle. The address-latch pulse normally fires twice per cycle. A data-memory access drops the second pulse and uses one long read or write strobe instead of the short program-store strobe. Two timing marks tell the core where general-purpose ports are sampled and where they are updated.

Top module: `ext_bus_seq`

## Requirements
- R1: A request is taken only at the clock edge that ends clock 11 of a machine cycle; `req_ready` is high during clock 11 and nowhere else. A request presented at any other clock has no effect. `req_kind` encodes 0 = idle, 1 = code fetch, 2 = data read, 3 = data write.
- R2: `ale` is high during clocks 0–1 of every machine cycle. It is also high during clocks 6–7 of idle and fetch cycles. Each pulse lasts exactly 2 clocks.
- R3: In every non-idle cycle, `ad_oe` is high and `ad_out` carries the low address byte during clocks 0–2. That is one clock before `ale` falls and one clock after. A fetch cycle repeats this address phase during clocks 6–8.
- R4: In a fetch cycle, `psen_n` is low during clocks 3–5 only. The byte on `ad_in` at the end of clock 5 is returned on `rdata` with `rdata_valid` high during clock 6.
- R5: In a data read or write cycle, the second `ale` pulse is skipped and `psen_n` stays high. `rd_n` (read) or `wr_n` (write) is low during clocks 5–10 only.
- R6: In a write cycle, `ad_out` carries the write data with `ad_oe` high during clocks 3–11. The data is therefore present 2 clocks before `wr_n` falls and 1 clock after it rises.
- R7: In a non-idle cycle, `addr_hi` equals bits 15..8 of the accepted address for all 12 clocks.
- R8: `ad_oe` is low while `psen_n` or `rd_n` is low, and stays low until the next address phase. That covers clocks 3–5 of a fetch cycle and clocks 3–11 of a read cycle. Idle cycles never drive the port.
- R9: In a data read cycle, the byte on `ad_in` at the end of clock 10 is returned on `rdata` with `rdata_valid` high during clock 11. `rdata_valid` is never high for two clocks in a row.
- R10: `port_sample` is high during clock 9 (state 5, phase 2) of every cycle. `port_update` is high during clock 11 (state 6, phase 2) of every cycle.
- R11: While `rst` is high: `ale` is low; `psen_n`, `rd_n` and `wr_n` are high; `ad_oe` and `rdata_valid` are low. The first clock after reset is clock 0 of an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 idle, 1 fetch, 2 data read, 3 data write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | High in the last clock of a machine cycle |
| ale | output | 1 | Address latch pulse |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Multiplexed low address / write data |
| ad_oe | output | 1 | Drive enable for the multiplexed port |
| ad_in | input | 8 | Multiplexed port input |
| addr_hi | output | 8 | High address byte |
| rdata | output | 8 | Returned read byte |
| rdata_valid | output | 1 | One-clock pulse with `rdata` |
| port_sample | output | 1 | General port sample mark |
| port_update | output | 1 | General port output update mark |

## Verification
On every clock, the assertions check the following rules: the latch pulse width, the missing second pulse and idle program strobe during data accesses, that a strobe reading the bus never overlaps port drive, write-data setup and hold around the write strobe, a high address that only changes at the cycle boundary, and a valid flag that is a single pulse. Only the bench scenarios can show which exact clocks each strobe occupies and that the bytes returned are the right ones. These scenarios use modelled code and data memories fed through an external address latch. Back-to-back mixes of all four kinds are run, together with requests placed mid-cycle that must be ignored.

// File: rtl/ext_bus_seq_pkg.sv
package ext_bus_seq_pkg;

    localparam int CLKS_PER_STATE = 2;
    localparam int STATES_PER_CYC = 6;
    localparam int CYC_CLKS       = CLKS_PER_STATE * STATES_PER_CYC;
    localparam int PH_W           = $clog2(CYC_CLKS);

    localparam int ALE_LEN    = CLKS_PER_STATE;
    localparam int ALE2_START = CYC_CLKS / 2;
    localparam int ADDR_HOLD  = 1;
    localparam int ADDR_LEN   = ALE_LEN + ADDR_HOLD;
    localparam int PSEN_START = ALE_LEN + 1;
    localparam int PSEN_LEN   = 3;
    localparam int XSTB_START = ALE_LEN + 3;
    localparam int XSTB_LEN   = 6;
    localparam int SAMPLE_PH  = 4 * CLKS_PER_STATE + 1;
    localparam int UPDATE_PH  = 5 * CLKS_PER_STATE + 1;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FETCH = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } bus_op_e;

    typedef struct packed {
        logic ale;
        logic psen_n;
        logic rd_n;
        logic wr_n;
        logic oe;
        logic drive_data;
        logic cap;
        logic sample;
        logic update;
    } bus_ctl_t;

    function automatic logic in_win(int ph, int start, int len);
        return (ph >= start) && (ph < start + len);
    endfunction

    function automatic bus_ctl_t bus_decode(bus_op_e op, int ph);
        bus_ctl_t c;
        logic     xacc;
        xacc         = (op == OP_READ) || (op == OP_WRITE);
        c.ale        = in_win(ph, 0, ALE_LEN) || (!xacc && in_win(ph, ALE2_START, ALE_LEN));
        c.psen_n     = !((op == OP_FETCH) && in_win(ph, PSEN_START, PSEN_LEN));
        c.rd_n       = !((op == OP_READ) && in_win(ph, XSTB_START, XSTB_LEN));
        c.wr_n       = !((op == OP_WRITE) && in_win(ph, XSTB_START, XSTB_LEN));
        c.oe         = ((op != OP_IDLE) && in_win(ph, 0, ADDR_LEN))
                     || ((op == OP_FETCH) && in_win(ph, ALE2_START, ADDR_LEN))
                     || (op == OP_WRITE);
        c.drive_data = (op == OP_WRITE) && (ph >= ADDR_LEN);
        c.cap        = ((op == OP_FETCH) && (ph == PSEN_START + PSEN_LEN - 1))
                     || ((op == OP_READ) && (ph == XSTB_START + XSTB_LEN - 1));
        c.sample     = (ph == SAMPLE_PH);
        c.update     = (ph == UPDATE_PH);
        return c;
    endfunction

endpackage

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
    import ext_bus_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph,
    output logic            last
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_CLKS - 1);

    assign last = (ph == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst)       ph <= PH_LAST;
        else if (last) ph <= '0;
        else           ph <= ph + 1'b1;
    end
endmodule

// File: rtl/bus_req_latch.sv
module bus_req_latch
    import ext_bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output bus_op_e           op,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            op    <= OP_IDLE;
            addr  <= '0;
            wdata <= '0;
        end else if (accept) begin
            if (req_valid && (bus_op_e'(req_kind) != OP_IDLE)) begin
                op    <= bus_op_e'(req_kind);
                addr  <= req_addr;
                wdata <= req_wdata;
            end else begin
                op    <= OP_IDLE;
            end
        end
    end
endmodule

// File: rtl/bus_read_capture.sv
module bus_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= cap;
            if (cap) rdata <= ad_in;
        end
    end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ext_bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_valid,
    output logic                     port_sample,
    output logic                     port_update
);
    logic [PH_W-1:0]   ph;
    logic              last;
    bus_op_e           op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    bus_ctl_t          ctl;

    bus_cycle_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .ph   (ph),
        .last (last)
    );

    bus_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk       (clk),
        .rst       (rst),
        .accept    (last),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .op        (op),
        .addr      (addr),
        .wdata     (wdata)
    );

    assign ctl = bus_decode(op, int'(ph));

    bus_read_capture #(.DATA_W(DATA_W)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .cap         (ctl.cap),
        .ad_in       (ad_in),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

    assign req_ready   = last;
    assign ale         = ctl.ale;
    assign psen_n      = ctl.psen_n;
    assign rd_n        = ctl.rd_n;
    assign wr_n        = ctl.wr_n;
    assign ad_oe       = ctl.oe;
    assign ad_out      = ctl.drive_data ? wdata : addr[DATA_W-1:0];
    assign addr_hi     = addr[ADDR_W-1:DATA_W];
    assign port_sample = ctl.sample;
    assign port_update = ctl.update;
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_ready,
    input logic                     ale,
    input logic                     psen_n,
    input logic                     rd_n,
    input logic                     wr_n,
    input logic [DATA_W-1:0]        ad_out,
    input logic                     ad_oe,
    input logic [ADDR_W-DATA_W-1:0] addr_hi,
    input logic                     rdata_valid
);
    AST_ALE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale); // R2
    AST_ALE_MAX_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (ale && $past(ale)) |=> !ale); // R2
    AST_DATA_SKIPS_FETCH: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> (!ale && psen_n)); // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1); // R5
    AST_WR_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> (ad_oe && $past(ad_oe))); // R6
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (ad_oe && $stable(ad_out))); // R6
    AST_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(addr_hi)); // R7
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (!psen_n || !rd_n) |-> !ad_oe); // R8
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |=> !rdata_valid); // R9
endmodule

bind ext_bus_seq ext_bus_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .ale         (ale),
    .psen_n      (psen_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .ad_out      (ad_out),
    .ad_oe       (ad_oe),
    .addr_hi     (addr_hi),
    .rdata_valid (rdata_valid)
);

// File: tb/ext_bus_seq_bench.sv
module ext_bus_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready, ale, psen_n, rd_n, wr_n, ad_oe;
    logic [7:0]  ad_out, ad_in, addr_hi, rdata;
    logic        rdata_valid, port_sample, port_update;

    int checks = 0;
    int errors = 0;
    bit mem_live = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ext_bus_seq u_ext_bus_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi),
        .rdata(rdata), .rdata_valid(rdata_valid),
        .port_sample(port_sample), .port_update(port_update)
    );

    function automatic logic [7:0] code_of(logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // external memory models behind a low-address latch
    logic [7:0] xmem    [256];
    logic [7:0] ref_mem [256];
    logic [7:0] lat_lo;
    initial begin
        for (int i = 0; i < 256; i++) begin
            xmem[i]    = 8'(i) ^ 8'hA5;
            ref_mem[i] = 8'(i) ^ 8'hA5;
        end
    end
    always @(negedge ale) lat_lo = ad_out;
    always @(posedge wr_n) if (mem_live) xmem[lat_lo] = ad_out;
    assign ad_in = (psen_n == 1'b0) ? code_of({addr_hi, lat_lo})
                 : (rd_n == 1'b0)   ? xmem[lat_lo] : 8'hEE;

    // bench view of the cycle position and the accepted request
    int          tb_t;
    int          cur_op;
    logic [15:0] cur_addr;
    logic [7:0]  cur_wd;
    logic [7:0]  exp_rd;
    always @(posedge clk) begin
        if (rst) begin
            tb_t   <= 11;
            cur_op <= 0;
        end else if (tb_t == 11) begin
            tb_t <= 0;
            if (req_valid && req_kind != 2'd0) begin
                cur_op   <= int'(req_kind);
                cur_addr <= req_addr;
                cur_wd   <= req_wdata;
                exp_rd   <= (req_kind == 2'd1) ? code_of(req_addr) : ref_mem[req_addr[7:0]];
            end else begin
                cur_op <= 0;
            end
        end else begin
            tb_t <= tb_t + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0d op=%0d actual=%0h expected=%0h", req, tb_t, cur_op, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && mem_live && !done) begin
            bit       data, e_ale, e_psen, e_rd, e_wr, e_oe, e_val;
            logic [7:0] e_ad;
            data   = (cur_op == 2) || (cur_op == 3);
            e_ale  = (tb_t < 2) || (!data && (tb_t == 6 || tb_t == 7));
            e_psen = !(cur_op == 1 && tb_t >= 3 && tb_t <= 5);
            e_rd   = !(cur_op == 2 && tb_t >= 5 && tb_t <= 10);
            e_wr   = !(cur_op == 3 && tb_t >= 5 && tb_t <= 10);
            e_oe   = (cur_op != 0 && tb_t <= 2) || (cur_op == 1 && tb_t >= 6 && tb_t <= 8)
                   || (cur_op == 3);
            e_ad   = (cur_op == 3 && tb_t >= 3) ? cur_wd : cur_addr[7:0];
            e_val  = (cur_op == 1 && tb_t == 6) || (cur_op == 2 && tb_t == 11);
            chk(ale == e_ale, "R2 ale", int'(ale), int'(e_ale));
            chk(psen_n == e_psen, "R4 psen_n", int'(psen_n), int'(e_psen));
            chk(rd_n == e_rd, "R5 rd_n", int'(rd_n), int'(e_rd));
            chk(wr_n == e_wr, "R5 wr_n", int'(wr_n), int'(e_wr));
            chk(ad_oe == e_oe, "R8 ad_oe", int'(ad_oe), int'(e_oe));
            if (e_oe)
                chk(ad_out == e_ad, (cur_op == 3 && tb_t >= 3) ? "R6 wdata" : "R3 addr_lo",
                    int'(ad_out), int'(e_ad));
            if (cur_op != 0)
                chk(addr_hi == cur_addr[15:8], "R7 addr_hi", int'(addr_hi), int'(cur_addr[15:8]));
            chk(rdata_valid == e_val, (cur_op == 2) ? "R9 valid" : "R4 valid",
                int'(rdata_valid), int'(e_val));
            if (e_val)
                chk(rdata == exp_rd, (cur_op == 2) ? "R9 rdata" : "R4 rdata", int'(rdata), int'(exp_rd));
            chk(req_ready == (tb_t == 11), "R1 ready", int'(req_ready), int'(tb_t == 11));
            chk(port_sample == (tb_t == 9), "R10 sample", int'(port_sample), int'(tb_t == 9));
            chk(port_update == (tb_t == 11), "R10 update", int'(port_update), int'(tb_t == 11));
        end
    end

    task automatic issue(input int kind, input logic [15:0] a, input logic [7:0] wd, input bit stray);
        while (tb_t != 11) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_addr  = a;
        req_wdata = wd;
        if (kind == 3) ref_mem[a[7:0]] = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (stray) begin
            // R1: request presented mid-cycle must be ignored
            while (tb_t != 4) @(negedge clk);
            req_valid = 1'b1;
            req_kind  = 2'd3;
            req_addr  = ~a;
            req_wdata = 8'h99;
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(ale == 1'b0, "R11 ale", int'(ale), 0);
        chk(psen_n && rd_n && wr_n, "R11 strobes", int'({psen_n, rd_n, wr_n}), 7);
        chk(ad_oe == 1'b0, "R11 ad_oe", int'(ad_oe), 0);
        chk(rdata_valid == 1'b0, "R11 valid", int'(rdata_valid), 0);
        rst = 1'b0;
        mem_live = 1'b1;
        for (int r = 0; r < 64; r++) begin
            int          kind;
            logic [15:0] a;
            logic [7:0]  wd;
            if (r < 8) begin
                kind = 3; a = {8'(r * 37), 8'(r)};
            end else if (r < 16) begin
                kind = 2; a = {8'(r * 11), 8'(r - 8)};
            end else begin
                kind = (r * 7) % 4; a = 16'(r * 16'h0B3D);
            end
            wd = 8'(r * 29 + 7);
            issue(kind, a, wd, (r % 5) == 0);
        end
        issue(0, 16'h0, 8'h0, 1'b0);
        while (tb_t != 11) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule